// File: doc/BRIEF.md
# Reloading down-counter timer channel

One channel of a periodic timer. The channel holds a reload value and a live count. While enabled it decrements the count once for every strobe on the tick source it has selected. A strobe that finds the count at zero is an expiry: the count restarts from the reload value and the channel keeps running. Two single-cycle tick strobes come from outside the block and share the system clock domain. The slow strobe stands for a 1 MHz reference and the fast strobe stands for the 24 MHz bus clock.

The interrupt output is a level that inverts on each qualifying expiry; it does not pulse. Software acknowledges by tracking the level. An expiry qualifies when the overflow-interrupt enable is set or when either of the two match registers holds zero. Only zero can be stored in a match register. A write of any other value leaves the register unchanged. Clearing the enable stops the channel and snaps the count back to the reload value.

Top module: `reload_timer_chan`

## Requirements
- R1: After reset the count, the reload value, both match registers and the interrupt level are all 0.
- R2: While enabled, the count decreases by one on each strobe of the selected source. With no selected strobe and no write, it holds its value.
- R3: When ext_sel_i is 1 the slow strobe is counted and the fast strobe is ignored. When ext_sel_i is 0 the fast strobe is counted and the slow strobe is ignored.
- R4: A selected strobe that finds the count at 0 loads the count from the reload register on the next edge, so the channel repeats every reload+1 strobes.
- R5: irq_o inverts on an expiry when the channel is enabled and either ovf_irq_en_i is 1 or a match register holds 0. At any other time it holds its value.
- R6: A count write (cnt_wr_i) sets the count to wdata_i only while the channel is enabled. While the channel is disabled the write is discarded.
- R7: A reload write (reload_wr_i) stores wdata_i as the reload value and also loads it into the count, whether the channel is enabled or not.
- R8: While enable_i is 0 and no reload write is present, the count equals the reload value on the next edge.
- R9: A match write stores into the register picked by match_sel_i (0 or 1) only when wdata_i is 0. A non-zero write leaves both match registers unchanged.
- R10: Within one cycle a reload write takes precedence over a count write, and a count write takes precedence over a tick. No expiry happens in a cycle that carries either write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel run enable |
| ext_sel_i | input | 1 | Tick source select: 1 selects the slow strobe, 0 selects the fast strobe |
| ovf_irq_en_i | input | 1 | Overflow interrupt enable |
| slow_tick_i | input | 1 | Single-cycle slow tick strobe |
| fast_tick_i | input | 1 | Single-cycle fast tick strobe |
| wdata_i | input | CNT_W | Write data for the count, reload and match registers |
| cnt_wr_i | input | 1 | Count register write strobe |
| reload_wr_i | input | 1 | Reload register write strobe |
| match_wr_i | input | 1 | Match register write strobe |
| match_sel_i | input | $clog2(NUM_MATCH) | Index of the match register to write |
| count_o | output | CNT_W | Live count |
| reload_o | output | CNT_W | Reload value readback |
| match_o | output | NUM_MATCH x CNT_W | Match register readback |
| irq_o | output | 1 | Interrupt level, inverted on each qualifying expiry |

## Verification
The bench builds the channel with CNT_W = 8 and NUM_MATCH = 2. The narrow width makes the largest reload value, 255, cheap to write. It also lets runs with a reload of 0, where every strobe expires, and runs with short periods produce many irq_o inversions in a few hundred cycles. The bench changes the fast strobe's rate while the slow strobe keeps a fixed rate. This separates the two sources, so a channel counting the wrong source goes out of step with the bench model within a few cycles.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD    = 2'd0,
    CNT_DEC     = 2'd1,
    CNT_RESTART = 2'd2,
    CNT_SET     = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/rtc_tick_sel.sv
module rtc_tick_sel (
  input  logic enable_i,
  input  logic ext_sel_i,
  input  logic slow_tick_i,
  input  logic fast_tick_i,
  output logic tick_o
);
  always_comb tick_o = enable_i & (ext_sel_i ? slow_tick_i : fast_tick_i);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else begin
      unique case (op_i)
        CNT_DEC:     count_q <= count_q - 1'b1;
        CNT_RESTART: count_q <= reload_i;
        CNT_SET:     count_q <= wdata_i;
        default:     count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;
  assign zero_o  = (count_q == '0);

  // R2: a decrement never crosses zero
  a_r2_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_DEC) |-> !zero_o);
endmodule

// File: rtl/rtc_match_regs.sv
module rtc_match_regs #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 2,
  localparam int SEL_W    = $clog2(NUM_MATCH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [CNT_W-1:0]                wdata_i,
  output logic [NUM_MATCH-1:0][CNT_W-1:0] match_o,
  output logic                            any_zero_o
);
  logic [NUM_MATCH-1:0] is_zero;
  logic                 wdata_zero;

  assign wdata_zero = (wdata_i == '0);

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_match
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && wdata_zero && (sel_i == SEL_W'(g))) q <= wdata_i;
    end
    assign match_o[g] = q;
    assign is_zero[g] = (q == '0);
  end

  assign any_zero_o = |is_zero;

  // R9: non-zero data never alters a match register
  a_r9_nonzero_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_zero) |=> $stable(match_o));
endmodule

// File: rtl/rtc_irq_toggle.sv
module rtc_irq_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic arm_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else if (expire_i && arm_i) irq_q <= ~irq_q;
  end

  assign irq_o = irq_q;

  // R5: level moves only on a qualifying expiry
  a_r5_level_only_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(expire_i && arm_i) |=> $stable(irq_q));
  a_r5_level_inverts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && arm_i) |=> (irq_q != $past(irq_q)));
endmodule

// File: rtl/reload_timer_chan.sv
module reload_timer_chan
  import reload_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 2,
  localparam int SEL_W    = $clog2(NUM_MATCH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            enable_i,
  input  logic                            ext_sel_i,
  input  logic                            ovf_irq_en_i,
  input  logic                            slow_tick_i,
  input  logic                            fast_tick_i,
  input  logic [CNT_W-1:0]                wdata_i,
  input  logic                            cnt_wr_i,
  input  logic                            reload_wr_i,
  input  logic                            match_wr_i,
  input  logic [SEL_W-1:0]                match_sel_i,
  output logic [CNT_W-1:0]                count_o,
  output logic [CNT_W-1:0]                reload_o,
  output logic [NUM_MATCH-1:0][CNT_W-1:0] match_o,
  output logic                            irq_o
);
  logic [CNT_W-1:0] reload_q;
  logic             tick, cnt_zero, any_zero, expire;
  cnt_op_e          op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          reload_q <= '0;
    else if (reload_wr_i) reload_q <= wdata_i;
  end

  rtc_tick_sel i_tick_sel (
    .enable_i   (enable_i),
    .ext_sel_i  (ext_sel_i),
    .slow_tick_i(slow_tick_i),
    .fast_tick_i(fast_tick_i),
    .tick_o     (tick)
  );

  // reload write > disable > count write > tick
  always_comb begin
    op     = CNT_HOLD;
    expire = 1'b0;
    if (reload_wr_i)   op = CNT_SET;
    else if (!enable_i) op = CNT_RESTART;
    else if (cnt_wr_i) op = CNT_SET;
    else if (tick) begin
      if (cnt_zero) begin
        op     = CNT_RESTART;
        expire = 1'b1;
      end else begin
        op = CNT_DEC;
      end
    end
  end

  rtc_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .wdata_i (wdata_i),
    .reload_i(reload_q),
    .count_o (count_o),
    .zero_o  (cnt_zero)
  );

  rtc_match_regs #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) i_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (match_wr_i),
    .sel_i     (match_sel_i),
    .wdata_i   (wdata_i),
    .match_o   (match_o),
    .any_zero_o(any_zero)
  );

  rtc_irq_toggle i_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .expire_i(expire),
    .arm_i   (ovf_irq_en_i | any_zero),
    .irq_o   (irq_o)
  );

  assign reload_o = reload_q;

  a_r7_reload_loads_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_wr_i |=> (count_o == $past(wdata_i)) && (reload_o == $past(wdata_i)));
  a_r8_disable_snaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !reload_wr_i) |=> (count_o == $past(reload_o)));
  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !(ext_sel_i ? slow_tick_i : fast_tick_i) && !cnt_wr_i && !reload_wr_i)
      |=> $stable(count_o));
  a_r4_restart_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && (ext_sel_i ? slow_tick_i : fast_tick_i) && count_o == '0
     && !cnt_wr_i && !reload_wr_i) |=> (count_o == $past(reload_o)));
  a_r10_write_blocks_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i || reload_wr_i) |=> $stable(irq_o));
endmodule

// File: tb/test_reload_timer_chan.sv
module test_reload_timer_chan;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, ext = 0, ovf = 0, slow = 0, fast = 0;
  logic [W-1:0] wd = '0;
  logic cwr = 0, rwr = 0, mwr = 0;
  logic [0:0] msel = '0;
  logic [W-1:0] count, reload;
  logic [1:0][W-1:0] match;
  logic irq;

  always #10 clk = ~clk;

  reload_timer_chan #(.CNT_W(W), .NUM_MATCH(2)) i_reload_timer_chan (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .ext_sel_i(ext),
    .ovf_irq_en_i(ovf), .slow_tick_i(slow), .fast_tick_i(fast),
    .wdata_i(wd), .cnt_wr_i(cwr), .reload_wr_i(rwr), .match_wr_i(mwr),
    .match_sel_i(msel), .count_o(count), .reload_o(reload),
    .match_o(match), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, fast_div = 1;
  bit compare_on = 1'b1;
  int m_cnt, m_rel, m_m0, m_m1, m_irq;

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_m0 = 0; m_m1 = 0; m_irq = 0;
    end else begin
      bit tk;
      tk = en && (ext ? slow : fast);
      if (mwr && wd == 0) begin
        if (msel == 1'b1) m_m1 = 0; else m_m0 = 0;
      end
      if (rwr) begin
        m_rel = int'(wd); m_cnt = int'(wd);
      end else if (!en) m_cnt = m_rel;
      else if (cwr) m_cnt = int'(wd);
      else if (tk) begin
        if (m_cnt == 0) begin
          m_cnt = m_rel;
          if (ovf || m_m0 == 0 || m_m1 == 0) m_irq = 1 - m_irq;
        end else m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle compare and strobe generation
  always @(negedge clk) begin
    cyc++;
    if (compare_on) begin
      check("R2 R4 R6 R7 R8 R10 count", int'(count), m_cnt);
      check("R7 reload", int'(reload), m_rel);
      check("R9 match0", int'(match[0]), m_m0);
      check("R9 match1", int'(match[1]), m_m1);
      check("R5 irq", int'(irq), m_irq);
    end
    #1;
    slow = (cyc % 7 == 0);
    fast = (cyc % fast_div == 0);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulse_wr(input int kind, input int val);
    wd = W'(val);
    if (kind == 0) cwr = 1; else if (kind == 1) rwr = 1; else mwr = 1;
    step(1);
    cwr = 0; rwr = 0; mwr = 0;
  endtask

  initial begin
    step(3);
    check("R1 count", int'(count), 0);
    check("R1 reload", int'(reload), 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1;
    step(2);
    // disabled: reload write loads count, count write dropped
    pulse_wr(1, 5);
    check("R7 count after reload write", int'(count), 5);
    pulse_wr(0, 99);
    check("R6 disabled count write", int'(count), 5);
    msel = 1; pulse_wr(2, 17);
    check("R9 nonzero match1", int'(match[1]), 0);
    msel = 0; pulse_wr(2, 0);
    check("R9 zero match0", int'(match[0]), 0);
    // fast source every cycle
    en = 1; ext = 0; fast_div = 1;
    step(40);
    fast_div = 3; step(30);
    // slow source, fast strobes ignored
    ext = 1; fast_div = 1; step(50);
    pulse_wr(0, 2);
    check("R6 enabled count write", int'(count), 2);
    step(30);
    // all writes and a tick at once
    ext = 0; wd = 9; cwr = 1; rwr = 1; step(1); cwr = 0; rwr = 0;
    check("R10 reload wins", int'(count), 9);
    wd = 1; cwr = 1; step(1); cwr = 0;
    check("R10 count write beats tick", int'(count), 1);
    step(25);
    en = 0; step(1);
    check("R8 disable snaps to reload", int'(count), 9);
    step(5);
    // reload zero: every tick expires
    pulse_wr(1, 0); en = 1; ovf = 1; step(20);
    // maximum reload
    pulse_wr(1, 255); step(10);
    pulse_wr(0, 0); step(5);
    ext = 1; step(300);
    fast_div = 2; ext = 0; step(600);
    check("R3 R4 final count", int'(count), m_cnt);
    compare_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule